// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a 16-bit timing word into CAN bit timing and samples the receive line at the right instant of every bit. A prescaler divides the CAN clock down to the time quantum (Tq). Each bit then runs through four segments: a 1 Tq synchronization segment, a propagation segment, phase segment A and phase segment B. The sample point sits at the end of phase segment A. The transmit point is the start of the next synchronization segment.

Once enabled, the unit hunts for the first recessive-to-dominant edge on the receive line and hard-synchronizes to it. Later falling edges resynchronize the bit: an edge that comes early in the bit stretches phase segment A, and an edge that comes after the sample point cuts phase segment B short. Either change is limited by the jump width, and only one such change is made per bit. The receive line is looked at once per quantum. The bit value is taken either from the single sample at the sample point or from a majority vote over three samples.

Top module: `can_bit_timing`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `sample_stb`, `tx_stb` and `cfg_err` are 0 and `rx_bit` is 1 (recessive).
- R2: One quantum lasts `cfg[3:0]`+1 clock cycles. Two consecutive sample strobes of an undisturbed bit stream are therefore (`cfg[3:0]`+1) × (bit length in Tq) cycles apart.
- R3: A bit is 1 + P + A + B quanta long. The propagation segment P is `cfg[7:5]`+1 Tq. Phase segment A is `cfg[10:8]`+1 Tq and phase segment B is `cfg[13:11]`+1 Tq. `sample_stb` marks the quantum that ends phase segment A, and `tx_stb` marks the quantum that ends phase segment B.
- R4: A phase segment code of 000 is used as 2 Tq. While either phase field holds 000, `cfg_err` is 1 from the following cycle on.
- R5: After `en` rises, no strobe appears until a recessive-to-dominant edge is seen. The quantum in which that edge is seen becomes the synchronization segment. With `cfg[3:0]`=0 and `rx_raw` falling just before clock edge 1, the first `sample_stb` is seen after clock edge 2+P+A.
- R6: `cfg[4]`=0 sets `rx_bit` to the single sample taken at the sample point. `cfg[4]`=1 sets it to the majority of the samples taken on the last three quanta up to and including the sample point. `rx_bit` changes only together with `sample_stb`.
- R7: A falling edge seen in quantum p of a bit, with 1 ≤ p < P+A, stretches phase segment A by min(p, J) quanta, where J = `cfg[15:14]`+1.
- R8: A falling edge seen in quantum p after the sample point has a phase error e = (quanta left in the bit including p). If e ≤ J, quantum p becomes the synchronization segment of the next bit. Otherwise phase segment B is shortened by J.
- R9: An edge in the synchronization segment or in the sample quantum is ignored. Only the first qualifying edge in a bit resynchronizes it.
- R10: While `en` is low, no strobe is produced. Raising `en` again restarts the hunt for an edge.
- R11: Each strobe is one cycle wide, and `sample_stb` and `tx_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CAN clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the unit idle |
| cfg | input | 16 | Timing word: prescaler, sampling mode, segment and jump-width codes |
| rx_raw | input | 1 | Receive line, 1 is recessive |
| rx_bit | output | 1 | Sampled bit value |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| tx_stb | output | 1 | One-cycle pulse at the transmit point |
| cfg_err | output | 1 | A phase segment field holds the reserved code |

## Verification
The jump-width limit checks compare the stored stretch and cut amounts with the jump width decoded from the live timing word. They therefore assume that `cfg` is written only while `en` is low. The bench changes the word one idle cycle after dropping `en`, and it holds the word steady for a whole run. The strobe and hold properties assume that `rx_raw` is driven away from the clock edge. The bench drives all inputs on the falling clock edge, so each change is captured exactly once.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int BRP_W = 4;
  localparam int SEG_W = 3;
  localparam int SJW_W = 2;
  localparam int LEN_W = 6;

  typedef struct packed {
    logic [SJW_W-1:0] sjw;
    logic [SEG_W-1:0] ph_b;
    logic [SEG_W-1:0] ph_a;
    logic [SEG_W-1:0] prop;
    logic             triple;
    logic [BRP_W-1:0] brp;
  } bt_word_t;

  function automatic logic [LEN_W-1:0] code_len(input logic [SEG_W-1:0] c);
    return LEN_W'(c) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] phase_len(input logic [SEG_W-1:0] c);
    return (c == '0) ? LEN_W'(2) : LEN_W'(c) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] jump_len(input logic [SJW_W-1:0] c);
    return LEN_W'(c) + LEN_W'(1);
  endfunction
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = en && (cnt >= div);

  always_ff @(posedge clk) begin
    if (rst || !en)     cnt <= '0;
    else if (cnt >= div) cnt <= '0;
    else                cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/cbt_sequencer.sv
module cbt_sequencer #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          rx_s,
  input  logic [LW-1:0] prop_len,
  input  logic [LW-1:0] pha_len,
  input  logic [LW-1:0] phb_len,
  input  logic [LW-1:0] sjw_len,
  output logic          sample_pt,
  output logic          tx_stb,
  output logic [LW-1:0] ext_o,
  output logic [LW-1:0] cut_o
);
  logic          hunting, last_rx, rs_done;
  logic [LW-1:0] pos, ext_q, cut_q;
  logic          fall, can_rs, len_case, cut_case, jump, bit_end;
  logic [LW-1:0] sp_cur, end_cur, err_b, ext_n, cut_n, sp_n, end_n;

  always_comb begin
    fall     = last_rx && !rx_s;
    can_rs   = fall && !hunting && !rs_done && (pos != '0);
    sp_cur   = prop_len + pha_len + ext_q;
    end_cur  = sp_cur + phb_len - cut_q;
    len_case = can_rs && (pos < sp_cur);
    cut_case = can_rs && (pos > sp_cur);
    err_b    = end_cur + LW'(1) - pos;
    jump     = cut_case && (err_b <= sjw_len);
    ext_n    = len_case ? ((pos < sjw_len) ? pos : sjw_len) : ext_q;
    cut_n    = (cut_case && !jump) ? sjw_len : cut_q;
    sp_n     = prop_len + pha_len + ext_n;
    end_n    = sp_n + phb_len - cut_n;
    sample_pt = tick && !hunting && (pos == sp_n);
    bit_end   = tick && !hunting && !jump && (pos == end_n);
  end

  assign ext_o = ext_q;
  assign cut_o = cut_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hunting <= 1'b1;
      last_rx <= 1'b1;
      rs_done <= 1'b0;
      pos     <= '0;
      ext_q   <= '0;
      cut_q   <= '0;
      tx_stb  <= 1'b0;
    end else begin
      tx_stb <= 1'b0;
      if (tick) begin
        last_rx <= rx_s;
        if (hunting) begin
          if (fall) begin
            hunting <= 1'b0;
            pos     <= LW'(1);
            ext_q   <= '0;
            cut_q   <= '0;
            rs_done <= 1'b0;
          end
        end else if (jump || bit_end) begin
          pos     <= jump ? LW'(1) : '0;
          ext_q   <= '0;
          cut_q   <= '0;
          rs_done <= 1'b0;
          tx_stb  <= 1'b1;
        end else begin
          pos     <= pos + LW'(1);
          ext_q   <= ext_n;
          cut_q   <= cut_n;
          rs_done <= rs_done || len_case || cut_case;
        end
      end
    end
  end
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic rx_s,
  input  logic triple,
  input  logic sample_pt,
  output logic rx_bit,
  output logic sample_stb
);
  logic [1:0] hist;
  logic       vote;

  assign vote = (hist[1] & hist[0]) | (hist[1] & rx_s) | (hist[0] & rx_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist       <= 2'b11;
      rx_bit     <= 1'b1;
      sample_stb <= 1'b0;
    end else if (!en) begin
      hist       <= 2'b11;
      sample_stb <= 1'b0;
    end else begin
      sample_stb <= sample_pt;
      if (tick) hist <= {hist[0], rx_s};
      if (sample_pt) rx_bit <= triple ? vote : rx_s;
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [15:0] cfg,
  input  logic        rx_raw,
  output logic        rx_bit,
  output logic        sample_stb,
  output logic        tx_stb,
  output logic        cfg_err
);
  bt_word_t          w;
  logic              rx_s, tick, sample_pt;
  logic [LEN_W-1:0]  prop_len, pha_len, phb_len, sjw_len, ext_len, cut_len;

  assign w        = bt_word_t'(cfg);
  assign prop_len = code_len(w.prop);
  assign pha_len  = phase_len(w.ph_a);
  assign phb_len  = phase_len(w.ph_b);
  assign sjw_len  = jump_len(w.sjw);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s    <= 1'b1;
      cfg_err <= 1'b0;
    end else begin
      rx_s    <= rx_raw;
      cfg_err <= (w.ph_a == '0) || (w.ph_b == '0);
    end
  end

  cbt_prescaler #(.W(BRP_W)) u_pre (
    .clk(clk), .rst(rst), .en(en), .div(w.brp), .tick(tick)
  );

  cbt_sequencer #(.LW(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .rx_s(rx_s),
    .prop_len(prop_len), .pha_len(pha_len), .phb_len(phb_len),
    .sjw_len(sjw_len), .sample_pt(sample_pt), .tx_stb(tx_stb),
    .ext_o(ext_len), .cut_o(cut_len)
  );

  cbt_sampler u_smp (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .rx_s(rx_s),
    .triple(w.triple), .sample_pt(sample_pt),
    .rx_bit(rx_bit), .sample_stb(sample_stb)
  );
endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk #(
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          rx_bit,
  input logic          sample_stb,
  input logic          tx_stb,
  input logic [LW-1:0] ext_len,
  input logic [LW-1:0] cut_len,
  input logic [LW-1:0] sjw_len
);
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && tx_stb)); // R11
  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sample_stb && !tx_stb)); // R10
  AST_EXT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    ext_len <= sjw_len); // R7
  AST_CUT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cut_len <= sjw_len); // R8
  AST_RXBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_bit) |-> sample_stb); // R6
endmodule

bind can_bit_timing can_bit_timing_chk #(.LW(can_bt_pkg::LEN_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .rx_bit(rx_bit),
  .sample_stb(sample_stb), .tx_stb(tx_stb),
  .ext_len(ext_len), .cut_len(cut_len), .sjw_len(sjw_len)
);

// File: tb/tb_can_bit_timing.sv
module tb_can_bit_timing;
  localparam int CLK_P = 10;
  localparam int N     = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] cfg = 16'h0;
  logic        rx_raw = 1'b1;
  logic        rx_bit, sample_stb, tx_stb, cfg_err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic smp [N];
  logic txa [N];
  logic bv  [N];

  can_bit_timing dut (
    .clk(clk), .rst(rst), .en(en), .cfg(cfg), .rx_raw(rx_raw),
    .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_stb(tx_stb), .cfg_err(cfg_err)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] mk(input int sjw, input int phb, input int pha,
                                     input int prop, input bit tri3, input int brp);
    return {sjw[1:0], phb[2:0], pha[2:0], prop[2:0], tri3, brp[3:0]};
  endfunction

  function automatic logic [N-1:0] ones(input int a, input int b);
    logic [N-1:0] v = '0;
    for (int k = 0; k < N; k++) if (k >= a && k <= b) v[k] = 1'b1;
    return v;
  endfunction

  function automatic int nxs(input int from);
    for (int k = 0; k < N; k++) if (k >= from && smp[k]) return k;
    return -1;
  endfunction

  function automatic int nxt(input int from);
    for (int k = 0; k < N; k++) if (k >= from && txa[k]) return k;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // rx pattern bit k is driven on falling edge k; edge 0 is the first driven one
  task automatic run(input logic [15:0] c, input logic [N-1:0] pat);
    @(negedge clk); en = 1'b0; rx_raw = 1'b1;
    @(negedge clk); cfg = c;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      if (k > 0) @(negedge clk);
      smp[k] = sample_stb;
      txa[k] = tx_stb;
      bv[k]  = rx_bit;
      rx_raw = pat[k];
    end
  endtask

  task automatic t_reset();
    cfg = mk(0, 1, 2, 1, 0, 0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(sample_stb == 0 && tx_stb == 0, "R1 strobes in reset", {sample_stb, tx_stb}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sample_stb == 0 && tx_stb == 0, "R1 strobes after reset", {sample_stb, tx_stb}, 0);
    chk(cfg_err == 0, "R1 cfg_err", cfg_err, 0);
    chk(rx_bit == 1, "R1 rx_bit", rx_bit, 1);
  endtask

  task automatic t_basic();
    int s1, s2, t1, both, dbl;
    run(mk(0, 1, 2, 1, 0, 0), '0);
    s1 = nxs(0); t1 = nxt(0); s2 = nxs(s1 + 1);
    chk(s1 == 7, "R5 first sample after hard sync", s1, 7);
    chk(t1 == 9, "R3 transmit point", t1, 9);
    chk(s2 == 15, "R3 bit length", s2, 15);
    chk(bv[s1] == 0, "R6 dominant sampled", bv[s1], 0);
    both = 0; dbl = 0;
    for (int k = 0; k < N; k++) begin
      if (smp[k] && txa[k]) both++;
      if (k > 0 && smp[k] && smp[k-1]) dbl++;
    end
    chk(both == 0 && dbl == 0, "R11 strobe shape", both + dbl, 0);
  endtask

  task automatic t_prescale();
    int s1, s2, t1;
    run(mk(0, 1, 2, 1, 0, 2), '0);
    s1 = nxs(0); s2 = nxs(s1 + 1); t1 = nxt(s1 + 1);
    chk(s1 >= 0 && s2 - s1 == 24, "R2 sample spacing", s2 - s1, 24);
    chk(t1 - s1 == 6, "R2 sample to tx", t1 - s1, 6);
  endtask

  task automatic t_sampling();
    run(mk(0, 1, 2, 1, 0, 0), ones(5, N - 1));
    chk(bv[7] == 1, "R6 single sample", bv[7], 1);
    run(mk(0, 1, 2, 1, 1, 0), ones(5, N - 1));
    chk(bv[7] == 0, "R6 majority 0,0,1", bv[7], 0);
    run(mk(0, 1, 2, 1, 1, 0), ones(4, N - 1));
    chk(bv[7] == 1, "R6 majority 0,1,1", bv[7], 1);
  endtask

  task automatic t_lengthen();
    int s;
    run(mk(1, 1, 2, 1, 0, 0), ones(6, 9));
    s = nxs(8);
    chk(s == 17, "R7 stretch by phase error", s, 17);
    run(mk(1, 1, 2, 1, 0, 0), ones(6, 11));
    s = nxs(8);
    chk(s == 17, "R7 stretch limited by jump width", s, 17);
    run(mk(1, 1, 2, 1, 0, 0), ones(6, 8) | ones(10, 10));
    s = nxs(8);
    chk(s == 16, "R9 one resync per bit", s, 16);
    run(mk(1, 1, 2, 1, 0, 0), ones(6, 7));
    s = nxs(8);
    chk(s == 15, "R9 edge in sync segment ignored", s, 15);
  endtask

  task automatic t_shorten();
    int s, t;
    run(mk(0, 3, 1, 0, 0, 0), ones(4, 4));
    s = nxs(0);
    chk(s == 5, "R3 first sample", s, 5);
    t = nxt(0);
    chk(t == 8, "R8 phase B cut by jump width", t, 8);
    s = nxs(6);
    chk(s == 12, "R8 next sample after cut", s, 12);
    run(mk(0, 3, 1, 0, 0, 0), ones(4, 6));
    s = nxs(6);
    chk(s == 12, "R8 edge quantum becomes sync", s, 12);
  endtask

  task automatic t_cfgerr();
    int s;
    run(mk(0, 1, 0, 1, 0, 0), '0);
    s = nxs(0);
    chk(s == 6, "R4 reserved code as 2 Tq", s, 6);
    chk(cfg_err == 1, "R4 cfg_err set", cfg_err, 1);
    run(mk(0, 1, 2, 1, 0, 0), '0);
    chk(cfg_err == 0, "R4 cfg_err clear", cfg_err, 0);
  endtask

  task automatic t_idle();
    int n = 0;
    @(negedge clk); en = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sample_stb || tx_stb) n++;
      rx_raw = k[0];
    end
    chk(n == 0, "R10 no strobes while disabled", n, 0);
    rx_raw = 1'b1;
    @(negedge clk); en = 1'b1;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sample_stb || tx_stb) n++;
    end
    chk(n == 0, "R5 hunt without edge", n, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_prescale();
    t_sampling();
    t_lengthen();
    t_shorten();
    t_cfgerr();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule